// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Sticky Error Flags

This block recovers characters from a single serial input line that idles high. A frame begins with one low start bit, carries 5 to 8 data bits least significant bit first, an optional parity bit, and ends with a high stop bit. Character length, parity use and parity sense, and the oversampling factor are set by configuration inputs. The factor is the number of `rx_tick` pulses per bit: 1, 16 or 64. The configuration is captured when a start bit is detected and held for the rest of that frame. The `rxd` input is expected to be synchronous to `clk` already.

A frame state machine walks through five states. `ST_IDLE` waits for a low line on a tick. Detection leads to `ST_START`, or straight to `ST_DATA` when the factor is 1. `ST_START` checks the line again after half a bit: a high line returns the machine to `ST_IDLE`, which is the false-start transition, and a low line leads to `ST_DATA`. `ST_DATA` samples one bit per bit period. After the last data bit it moves to `ST_PARITY` when parity is enabled and to `ST_STOP` otherwise. `ST_PARITY` samples one bit and then moves to `ST_STOP`. `ST_STOP` samples the stop bit, delivers the character and returns to `ST_IDLE`. Whenever the receive-enable input is low, every state goes to `ST_IDLE`.

A delivered character goes into a buffer register and raises a ready flag, which a read strobe clears. Parity, framing and overrun errors are kept in three sticky flags, which only an error-clear command input resets.

Top module: `serial_char_receiver`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_ready`, `err_parity`, `err_overrun` and `err_framing` are all 0.
- R2: Data bits are received least significant bit first. `cfg_len` codes 00, 01, 10 and 11 select 5, 6, 7 and 8 bits. The character appears right-aligned in `rx_data`, with unused upper bits 0, and `rx_data` changes only when a character completes.
- R3: `cfg_factor` code 10 selects 16 ticks per bit and code 11 selects 64. The start bit is confirmed N/2 ticks after the tick that first sees the line low, and each later bit is sampled every N ticks after that.
- R4: With factor 16 or 64, a line that is high again at the N/2 confirmation tick is a false start: the machine returns to idle and no character is delivered.
- R5: `cfg_factor` codes 00 and 01 select one tick per bit. A low line on a tick is taken as a start bit with no confirmation, and each following tick samples one bit.
- R6: When `cfg_par_en` is 1, a parity bit follows the data bits. `cfg_par_odd` 0 means the data bits plus the parity bit hold an even count of ones, and 1 means an odd count. A mismatch sets `err_parity`. When `cfg_par_en` is 0, no parity bit is expected.
- R7: A stop bit sampled low sets `err_framing`, and the character is still delivered.
- R8: When a character completes while `rx_ready` is 1 and no read strobe arrives in that cycle, `err_overrun` is set and the new character replaces the old one.
- R9: `rx_ready` rises in the clock cycle after the stop-bit sampling tick. `rd_strobe` clears it, except in a cycle where a character completes.
- R10: While `cmd_rx_en` is 0, the receiver stays idle and ignores the line. A frame in progress is abandoned and no character is delivered.
- R11: The error flags stay set until `cmd_err_clr` is 1. If a new error arrives in the same cycle as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data line, idle high |
| rx_tick | input | 1 | One-cycle oversampling pulse |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_factor | input | 2 | Ticks per bit code: 0x/01 = 1, 10 = 16, 11 = 64 |
| cmd_rx_en | input | 1 | Receive enable command |
| cmd_err_clr | input | 1 | Error flag clear command |
| rd_strobe | input | 1 | Host has read the buffer |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |

## Verification
Frames are sent with factor 16, 64 and 1, with every data length between 5 and 8 bits, with no parity, good even parity and bad odd parity, and with a low stop bit. Together these separate the bit timing, the alignment of the data and the parity sense. Short low pulses are tried under factor 16 and factor 1. Under factor 16 the pulse must be dropped. Under factor 1 it must become an all-ones character, which shows that the false-start check applies only to the oversampled factors. Two characters sent without a read in between check overrun and buffer replacement. Frames sent while disabled, and a frame cut off by dropping the enable, check that nothing is delivered.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAX_BITS  = 8;
    localparam int OS_HIGH   = 64;
    localparam int TCNT_W    = $clog2(OS_HIGH) + 1;
    localparam int BIDX_W    = $clog2(MAX_BITS);
    localparam int NBITS_W   = $clog2(MAX_BITS) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic [1:0] fact;
    } rx_cfg_t;

    function automatic logic [TCNT_W-1:0] ticks_per_bit(input logic [1:0] code);
        unique case (code)
            2'b10:   ticks_per_bit = TCNT_W'(16);
            2'b11:   ticks_per_bit = TCNT_W'(64);
            default: ticks_per_bit = TCNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/srx_bit_timer.sv
module srx_bit_timer
    import srx_pkg::*;
#(
    parameter int CNT_W = TCNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             half,
    input  logic [CNT_W-1:0] period,
    output logic             due
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;

    assign cnt_inc = cnt + 1'b1;
    assign target  = half ? (period >> 1) : period;
    assign due     = tick && !restart && (cnt_inc == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= due ? '0 : cnt_inc;
        end
    end

    // R3
    tick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> $stable(cnt));

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int NB = MAX_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  rx_cfg_t           cfg,
    input  logic              due,
    output logic              restart,
    output logic              half,
    output logic [TCNT_W-1:0] period,
    output logic              done,
    output logic [NB-1:0]     done_data,
    output logic              done_perr,
    output logic              done_ferr
);

    rx_state_t            state, state_nx;
    rx_cfg_t              cfg_q;
    logic [BIDX_W-1:0]    bit_idx;
    logic [NB-1:0]        shreg;
    logic                 par_acc;
    logic                 par_bit;
    logic [NBITS_W-1:0]   nbits;
    logic                 start_seen;

    assign nbits      = NBITS_W'(cfg_q.len) + NBITS_W'(5);
    assign start_seen = (state == ST_IDLE) && tick && !rxd && rx_en;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_seen) begin
                    state_nx = (ticks_per_bit(cfg.fact) == TCNT_W'(1)) ? ST_DATA : ST_START;
                end
            end
            ST_START: begin
                if (due) state_nx = rxd ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (due && (NBITS_W'(bit_idx) == nbits - 1'b1)) begin
                    state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (due) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (due) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (!rx_en) state_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bit <= 1'b0;
        end else if (start_seen) begin
            cfg_q   <= cfg;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bit <= 1'b0;
        end else if (due && state == ST_DATA) begin
            shreg   <= {rxd, shreg[NB-1:1]};
            par_acc <= par_acc ^ rxd;
            bit_idx <= bit_idx + 1'b1;
        end else if (due && state == ST_PARITY) begin
            par_bit <= rxd;
        end
    end

    // outputs
    always_comb begin
        restart   = (state == ST_IDLE);
        half      = (state == ST_START);
        period    = ticks_per_bit(cfg_q.fact);
        done      = (state == ST_STOP) && due && rx_en;
        done_data = shreg >> (NBITS_W'(NB) - nbits);
        done_perr = cfg_q.par_en && (par_acc ^ par_bit ^ cfg_q.par_odd);
        done_ferr = !rxd;
    end

    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE));

    // R4
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && due && rxd && rx_en) |=> (state == ST_IDLE));

    // R5
    x1_no_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> (ticks_per_bit(cfg_q.fact) != TCNT_W'(1)));

endmodule

// File: rtl/srx_status_regs.sv
module srx_status_regs
    import srx_pkg::*;
#(
    parameter int NB = MAX_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [NB-1:0] done_data,
    input  logic          done_perr,
    input  logic          done_ferr,
    input  logic          rd,
    input  logic          err_clr,
    output logic [NB-1:0] rx_data,
    output logic          rx_ready,
    output logic          err_par,
    output logic          err_ovr,
    output logic          err_frm
);

    logic ovr_hit;
    assign ovr_hit = done && rx_ready && !rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            err_par  <= 1'b0;
            err_ovr  <= 1'b0;
            err_frm  <= 1'b0;
        end else begin
            if (done) rx_data <= done_data;
            if (done)    rx_ready <= 1'b1;
            else if (rd) rx_ready <= 1'b0;
            err_par <= (done && done_perr) || (err_par && !err_clr);
            err_frm <= (done && done_ferr) || (err_frm && !err_clr);
            err_ovr <= ovr_hit || (err_ovr && !err_clr);
        end
    end

    // R9
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !rx_ready);

    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_ready && !rd) |=> err_ovr);

    // R11
    sticky_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par && !err_clr) |=> err_par);

    // R11
    sticky_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frm && !err_clr) |=> err_frm);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_data));

endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       rx_tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_factor,
    input  logic       cmd_rx_en,
    input  logic       cmd_err_clr,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       err_framing
);

    rx_cfg_t           cfg;
    logic              restart;
    logic              half;
    logic              due;
    logic [TCNT_W-1:0] period;
    logic              done;
    logic [7:0]        done_data;
    logic              done_perr;
    logic              done_ferr;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, fact: cfg_factor};

    srx_bit_timer #(.CNT_W(TCNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (rx_tick),
        .restart (restart),
        .half    (half),
        .period  (period),
        .due     (due)
    );

    srx_frame_fsm #(.NB(8)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rx_tick),
        .rxd       (rxd),
        .rx_en     (cmd_rx_en),
        .cfg       (cfg),
        .due       (due),
        .restart   (restart),
        .half      (half),
        .period    (period),
        .done      (done),
        .done_data (done_data),
        .done_perr (done_perr),
        .done_ferr (done_ferr)
    );

    srx_status_regs #(.NB(8)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_data (done_data),
        .done_perr (done_perr),
        .done_ferr (done_ferr),
        .rd        (rd_strobe),
        .err_clr   (cmd_err_clr),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .err_par   (err_parity),
        .err_ovr   (err_overrun),
        .err_frm   (err_framing)
    );

endmodule

// File: tb/test_serial_char_receiver.sv
`timescale 1ns/1ps
module test_serial_char_receiver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_tick = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_factor = 2'b10;
    logic       cmd_rx_en = 1'b1;
    logic       cmd_err_clr = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_overrun, err_framing;

    int n_total = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    serial_char_receiver i_serial_char_receiver (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_tick(rx_tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_factor(cfg_factor), .cmd_rx_en(cmd_rx_en), .cmd_err_clr(cmd_err_clr),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_overrun(err_overrun), .err_framing(err_framing)
    );

    // one tick every other clock
    always @(negedge clk) rx_tick <= !rx_tick;

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int fac(logic [1:0] code);
        if (code == 2'b10) return 16;
        if (code == 2'b11) return 64;
        return 1;
    endfunction

    // behavioural reference model
    bit       m_busy;
    int       m_cnt, m_n, m_len, m_total;
    bit       m_pen, m_podd;
    bit       m_q[$];
    logic [7:0] e_data;
    bit       e_ready, e_perr, e_oerr, e_ferr;

    always @(posedge clk) begin
        bit fin, nperr, nferr, par, oset;
        logic [7:0] nd;
        fin = 0; nperr = 0; nferr = 0; par = 0; nd = '0;
        if (!rst_n) begin
            m_busy = 0; e_data = '0; e_ready = 0; e_perr = 0; e_oerr = 0; e_ferr = 0;
        end else begin
            if (!cmd_rx_en) begin
                m_busy = 0;
            end else if (rx_tick) begin
                if (!m_busy) begin
                    if (!rxd) begin
                        m_busy = 1; m_cnt = 0; m_n = fac(cfg_factor);
                        m_len = int'(cfg_len) + 5; m_pen = cfg_par_en; m_podd = cfg_par_odd;
                        m_total = m_len + (m_pen ? 1 : 0) + 1;
                        m_q.delete();
                    end
                end else begin
                    m_cnt++;
                    if (m_n > 1 && m_cnt == m_n / 2) begin
                        if (rxd) m_busy = 0;
                    end else if (m_cnt > m_n / 2 && ((m_cnt - m_n / 2) % m_n) == 0) begin
                        m_q.push_back(rxd);
                        if (m_q.size() == m_total) begin
                            fin = 1; m_busy = 0;
                        end
                    end
                end
            end
            if (fin) begin
                for (int i = 0; i < m_len; i++) begin
                    nd[i] = m_q[i];
                    par ^= m_q[i];
                end
                nperr = m_pen && (par ^ m_q[m_len] ^ m_podd);
                nferr = !m_q[m_total-1];
            end
            oset    = fin && e_ready && !rd_strobe;
            e_oerr  = oset || (e_oerr && !cmd_err_clr);
            e_perr  = (fin && nperr) || (e_perr && !cmd_err_clr);
            e_ferr  = (fin && nferr) || (e_ferr && !cmd_err_clr);
            e_ready = fin ? 1'b1 : (rd_strobe ? 1'b0 : e_ready);
            if (fin) e_data = nd;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check_eq("R2 data", 32'(rx_data), 32'(e_data));
            check_eq("R9 ready", 32'(rx_ready), 32'(e_ready));
            check_eq("R6 parity flag", 32'(err_parity), 32'(e_perr));
            check_eq("R8 overrun flag", 32'(err_overrun), 32'(e_oerr));
            check_eq("R7 framing flag", 32'(err_framing), 32'(e_ferr));
        end
    end

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!rx_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] d, logic [1:0] lc, bit pen, bit podd,
                              bit bad_par, bit stop_v, logic [1:0] fc);
        int n, len;
        bit p;
        n = fac(fc); len = int'(lc) + 5; p = podd;
        cfg_len = lc; cfg_par_en = pen; cfg_par_odd = podd; cfg_factor = fc;
        rxd = 1'b0; wait_ticks(n);
        for (int i = 0; i < len; i++) begin
            rxd = d[i]; p ^= d[i]; wait_ticks(n);
        end
        if (pen) begin rxd = p ^ bad_par; wait_ticks(n); end
        rxd = stop_v; wait_ticks(n);
        rxd = 1'b1; wait_ticks(n + 2);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        cmd_err_clr = 1'b1; @(negedge clk); cmd_err_clr = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1 data", 32'(rx_data), 0);
        check_eq("R1 ready", 32'(rx_ready), 0);
        check_eq("R1 flags", {err_parity, err_overrun, err_framing}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        wait_ticks(4);

        // R2 R3 x16, 8 bits, no parity
        send_frame(8'hA5, 2'b11, 0, 0, 0, 1, 2'b10);
        check_eq("R2 x16 data", 32'(rx_data), 32'h A5);
        check_eq("R9 ready set", 32'(rx_ready), 1);
        pulse_rd();
        check_eq("R9 ready cleared by read", 32'(rx_ready), 0);

        // R3 R6 x64, 5 bits, even parity good; upper bits dropped (R2)
        send_frame(8'hF3, 2'b00, 1, 0, 0, 1, 2'b11);
        check_eq("R2 5-bit alignment", 32'(rx_data), 32'h13);
        check_eq("R6 good even parity", 32'(err_parity), 0);
        pulse_rd();

        // R6 x16, 7 bits, odd parity wrong
        send_frame(8'h41, 2'b10, 1, 1, 1, 1, 2'b10);
        check_eq("R6 bad odd parity", 32'(err_parity), 1);
        check_eq("R6 data kept", 32'(rx_data), 32'h41);
        pulse_rd();
        wait_ticks(20);
        check_eq("R11 parity flag sticky", 32'(err_parity), 1);
        pulse_clr();
        check_eq("R11 cleared", 32'(err_parity), 0);

        // R6 even parity good on 8 bits
        send_frame(8'h80, 2'b11, 1, 0, 0, 1, 2'b10);
        check_eq("R6 good even parity 8b", 32'(err_parity), 0);
        pulse_rd();

        // R5 R7 x1, 6 bits, low stop bit
        send_frame(8'h2A, 2'b01, 0, 0, 0, 0, 2'b01);
        check_eq("R7 framing set", 32'(err_framing), 1);
        check_eq("R5 x1 data", 32'(rx_data), 32'h2A);
        pulse_rd();
        pulse_clr();
        check_eq("R11 framing cleared", 32'(err_framing), 0);

        // R8 overrun
        send_frame(8'h11, 2'b11, 0, 0, 0, 1, 2'b10);
        send_frame(8'h22, 2'b11, 0, 0, 0, 1, 2'b10);
        check_eq("R8 overrun set", 32'(err_overrun), 1);
        check_eq("R8 data replaced", 32'(rx_data), 32'h22);
        pulse_rd();
        pulse_clr();

        // R4 false start under x16
        cfg_factor = 2'b10;
        rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(40);
        check_eq("R4 false start ignored", 32'(rx_ready), 0);
        check_eq("R4 data unchanged", 32'(rx_data), 32'h22);

        // R5 glitch under x1 becomes a character of ones
        cfg_factor = 2'b01; cfg_len = 2'b11; cfg_par_en = 1'b0;
        rxd = 1'b0; wait_ticks(1); rxd = 1'b1; wait_ticks(15);
        check_eq("R5 no start confirm", 32'(rx_ready), 1);
        check_eq("R5 ones char", 32'(rx_data), 32'hFF);
        pulse_rd();

        // R10 disabled receiver
        cmd_rx_en = 1'b0;
        send_frame(8'h5A, 2'b11, 0, 0, 0, 1, 2'b10);
        check_eq("R10 disabled no char", 32'(rx_ready), 0);
        check_eq("R10 data unchanged", 32'(rx_data), 32'hFF);
        cmd_rx_en = 1'b1;
        // abandon a frame in progress
        rxd = 1'b0; wait_ticks(16 + 48);
        cmd_rx_en = 1'b0; wait_ticks(2);
        rxd = 1'b1; wait_ticks(2);
        cmd_rx_en = 1'b1; wait_ticks(200);
        check_eq("R10 aborted frame", 32'(rx_ready), 0);

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule